// File: doc/BRIEF.md
# LCD frame and polarity generator

This block sets the frame timing and the AC-drive polarity of a passive-matrix LCD controller. A line strobe, one system-clock cycle wide and already derived from the LCD source clock, drives every counter. The frame counter counts strobes against a programmable 10-bit frame length. When it reaches that length it starts again and raises a frame pulse, which stays high for one line interval.

The polarity output inverts so that the panel sees no net DC bias. An enable input selects the inversion mode. With the enable low, the polarity inverts once per frame. With the enable high, it inverts every N line strobes, where N comes from a divider input. The N count restarts at every frame pulse, so the inversion pattern is the same in every frame. The divider setting never changes when the frame pulse occurs or how long it lasts.

Top module: `lcd_frame_polarity`

## Requirements
- R1: While reset is held, and after its release until the first line strobe, frame_pulse and polarity are both 0.
- R2: With frame length L (1 to 1023), frame_pulse rises on the L-th line strobe after reset and then on every L-th strobe after that.
- R3: frame_pulse is high from the wrapping strobe until the next line strobe, and that next strobe clears it unless it is itself a wrap.
- R4: Without a line strobe, neither frame_pulse nor polarity changes, however many clock cycles pass.
- R5: A frame length of 0 gives a frame of 1024 line strobes.
- R6: With inv_adj_en = 0, polarity inverts on each strobe that raises frame_pulse and on no other strobe.
- R7: With inv_adj_en = 1, polarity inverts on each strobe whose 1-based position within the current frame is a multiple of N. The position starts again at 1 after each frame pulse.
- R8: div_n and inv_adj_en have no effect on when frame_pulse occurs or how long it stays high.
- R9: A divider setting of 0 means N = 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_stb | input | 1 | One-cycle line strobe; all counting happens on it |
| frame_len | input | 10 | Frame length in line strobes; 0 means 1024 |
| div_n | input | 8 | Inversion interval N in line strobes; 0 means 256 |
| inv_adj_en | input | 1 | 1: invert every N strobes; 0: invert once per frame |
| frame_pulse | output | 1 | High for one line interval at each frame wrap |
| polarity | output | 1 | AC-drive polarity |

## Verification
The bench looks at the zero encodings of both settings. A design that reads 0 literally would wrap on every strobe or never invert, instead of giving 1024-line frames and 256-line inversion. It runs N-inversion with a frame length that N does not divide. A line counter that fails to restart at the frame pulse then lets the inversion phase drift from frame to frame, and the bench sees the toggles at the wrong strobes. It also leaves long gaps with no strobe after a wrap. A pulse timed in clock cycles rather than line intervals would then fall early, and the bench runs the same frame with inversion on and off to catch any pulse timing that depends on the divider.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  parameter int unsigned FLEN_W = 10;
  parameter int unsigned DIV_W  = 8;
  localparam int unsigned FCNT_W = FLEN_W + 1;
  localparam int unsigned DCNT_W = DIV_W + 1;

  typedef enum logic {
    POL_PER_FRAME = 1'b0,
    POL_PER_N     = 1'b1
  } pol_mode_e;
endpackage

// File: rtl/lfp_rst_sync.sv
module lfp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lfp_frame_counter.sv
module lfp_frame_counter
  import lfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic [FLEN_W-1:0] frame_len,
  output logic              wrap,
  output logic              frame_pulse
);
  logic [FLEN_W-1:0] cnt_q, cnt_d;
  logic              pulse_q, pulse_d;
  logic [FCNT_W-1:0] len_eff;
  logic [FCNT_W-1:0] cnt_inc;

  // zero encodes the full range
  assign len_eff = (frame_len == '0) ? FCNT_W'(1) << FLEN_W : {1'b0, frame_len};
  assign cnt_inc = {1'b0, cnt_q} + FCNT_W'(1);
  assign wrap    = line_stb && (cnt_inc >= len_eff);

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = pulse_q;
    if (line_stb) begin
      cnt_d   = wrap ? '0 : cnt_inc[FLEN_W-1:0];
      pulse_d = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign frame_pulse = pulse_q;

  // R3: the pulse lasts until the next strobe
  a_r3_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !line_stb) |=> pulse_q);
  // R2: the pulse only begins on a strobe
  a_r2_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(line_stb));
endmodule

// File: rtl/lfp_polarity.sv
module lfp_polarity
  import lfp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic             frame_wrap,
  input  logic [DIV_W-1:0] div_n,
  input  pol_mode_e        mode,
  output logic             polarity
);
  logic [DIV_W-1:0]  lc_q, lc_d;
  logic              pol_q, pol_d;
  logic [DCNT_W-1:0] n_eff;
  logic [DCNT_W-1:0] lc_inc;
  logic              n_hit;

  assign n_eff  = (div_n == '0) ? DCNT_W'(1) << DIV_W : {1'b0, div_n};
  assign lc_inc = {1'b0, lc_q} + DCNT_W'(1);
  assign n_hit  = lc_inc >= n_eff;

  always_comb begin
    lc_d  = lc_q;
    pol_d = pol_q;
    if (line_stb) begin
      if (mode == POL_PER_N) begin
        pol_d = pol_q ^ n_hit;
        lc_d  = (n_hit || frame_wrap) ? '0 : lc_inc[DIV_W-1:0];
      end else begin
        pol_d = pol_q ^ frame_wrap;
        lc_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q  <= '0;
      pol_q <= 1'b0;
    end else begin
      lc_q  <= lc_d;
      pol_q <= pol_d;
    end
  end

  assign polarity = pol_q;

  // R6: per-frame mode ignores non-wrapping strobes
  a_r6_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && mode == POL_PER_FRAME && !frame_wrap) |=> $stable(pol_q));
  // R7: line count restarts at each frame wrap
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && frame_wrap) |=> (lc_q == '0));
  // R7: reaching N inverts the output
  a_r7_invert_at_n: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && mode == POL_PER_N && n_hit) |=> (pol_q != $past(pol_q)));
endmodule

// File: rtl/lcd_frame_polarity.sv
module lcd_frame_polarity
  import lfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic [FLEN_W-1:0] frame_len,
  input  logic [DIV_W-1:0]  div_n,
  input  logic              inv_adj_en,
  output logic              frame_pulse,
  output logic              polarity
);
  logic      srst_n;
  logic      wrap;
  pol_mode_e mode;

  assign mode = inv_adj_en ? POL_PER_N : POL_PER_FRAME;

  lfp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lfp_frame_counter u_frame (
    .clk         (clk),
    .rst_n       (srst_n),
    .line_stb    (line_stb),
    .frame_len   (frame_len),
    .wrap        (wrap),
    .frame_pulse (frame_pulse)
  );

  lfp_polarity u_pol (
    .clk        (clk),
    .rst_n      (srst_n),
    .line_stb   (line_stb),
    .frame_wrap (wrap),
    .div_n      (div_n),
    .mode       (mode),
    .polarity   (polarity)
  );

  // R4: idle cycles leave both outputs alone
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!srst_n)
    !line_stb |=> ($stable(frame_pulse) && $stable(polarity)));
  // R1: outputs are low while reset is applied
  a_r1_reset_low: assert property (@(posedge clk)
    !srst_n |-> (!frame_pulse && !polarity));
endmodule

// File: tb/tb_lcd_frame_polarity.sv
module tb_lcd_frame_polarity;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_stb;
  logic [9:0] frame_len;
  logic [7:0] div_n;
  logic       inv_adj_en;
  logic       frame_pulse;
  logic       polarity;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lcd_frame_polarity dut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_len(frame_len),
    .div_n(div_n), .inv_adj_en(inv_adj_en),
    .frame_pulse(frame_pulse), .polarity(polarity)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int at);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s strobe=%0d actual=%0b expected=%0b", req, at, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; line_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", frame_pulse, 1'b0, 0);
    chk("R1", polarity, 1'b0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); line_stb = 1'b1;
    @(negedge clk); line_stb = 1'b0;
  endtask

  // Expected values come from R2/R5 (frame period) and R6/R7/R9 (inversion)
  task automatic run_seq(input int len, input bit en, input int n, input int count,
                         input string req_fp, input string req_pol);
    int len_e;
    int n_e;
    bit pol;
    len_e = (len == 0) ? 1024 : len;
    n_e   = (n == 0) ? 256 : n;
    frame_len = 10'(len); div_n = 8'(n); inv_adj_en = en;
    do_reset();
    chk("R1", frame_pulse, 1'b0, 0);
    chk("R1", polarity, 1'b0, 0);
    pol = 1'b0;
    for (int s = 1; s <= count; s++) begin
      int p;
      bit fp;
      p  = ((s - 1) % len_e) + 1;
      fp = (p == len_e);
      if (en) begin
        if ((p % n_e) == 0) pol = ~pol;
      end else if (fp) begin
        pol = ~pol;
      end
      strobe();
      chk(req_fp, frame_pulse, fp, s);
      chk(req_pol, polarity, pol, s);
    end
  endtask

  task automatic t_reset();
    frame_len = 10'd5; div_n = 8'd2; inv_adj_en = 1'b0;
    do_reset();
    repeat (10) @(negedge clk);
    chk("R1", frame_pulse, 1'b0, 0);
    chk("R1", polarity, 1'b0, 0);
  endtask

  task automatic t_frame_mode();
    run_seq(5, 1'b0, 3, 16, "R2", "R6");
  endtask

  task automatic t_idle_hold();
    frame_len = 10'd4; div_n = 8'd1; inv_adj_en = 1'b0;
    do_reset();
    repeat (4) strobe();
    repeat (25) begin
      @(negedge clk);
      chk("R3", frame_pulse, 1'b1, 4);
      chk("R4", polarity, 1'b1, 4);
    end
    strobe();
    chk("R3", frame_pulse, 1'b0, 5);
    chk("R4", polarity, 1'b1, 5);
  endtask

  task automatic t_len_zero();
    run_seq(0, 1'b0, 1, 1030, "R5", "R6");
  endtask

  task automatic t_n_mode();
    run_seq(7, 1'b1, 3, 23, "R8", "R7");
    run_seq(5, 1'b1, 2, 16, "R8", "R7");
    run_seq(6, 1'b1, 3, 14, "R8", "R7");
  endtask

  task automatic t_n_zero();
    run_seq(300, 1'b1, 0, 610, "R8", "R9");
  endtask

  initial begin
    rst_n = 1'b0; line_stb = 1'b0;
    frame_len = '0; div_n = '0; inv_adj_en = 1'b0;
    t_reset();
    t_frame_mode();
    t_idle_hold();
    t_len_zero();
    t_n_mode();
    t_n_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule